// File: doc/BRIEF.md
# Variable-Width Text Row Renderer

This block draws one raster line of a text row and emits it as a stream of colour indices. On a start strobe it takes the address where the row's screen bytes begin, the address where its colour bytes begin, and the pixel row inside the 8x8 character cell. It then walks the screen memory one character at a time. For each character it fetches the glyph byte from character memory and one colour byte from colour memory, and it shifts out that character's pixels with a valid strobe.

In wide mode each character takes two screen bytes. The first byte holds the low eight bits of a 12-bit character number. The second byte holds the high nibble of that number, a horizontal-mirror bit, a vertical-mirror bit and a two-bit width code. Narrowed characters keep only their leftmost pixels and pack tightly against the next character. A pair of 0xFF bytes ends the row early, so rows can hold different numbers of characters. In byte mode each character takes one byte and is drawn eight pixels wide.

When the line is finished the block reports the address of the first screen byte it did not consume. The caller uses that address to start the following row.

Top module: `textrow_render`

## Requirements
- R1: The glyph byte is read at character-memory address (character number × 8 + effective row). The character number is {second byte bits 3..0, first byte}. Bit 7 of the glyph byte is the leftmost pixel when the line is not mirrored.
- R2: In wide mode, second-byte bits 7..6 set the drawn width: 00 draws 8 pixels, 01 draws 6, 10 draws 4 and 11 draws 2.
- R3: A narrowed character draws only its leftmost pixels. The next character's first pixel follows on the very next valid pixel, with no gap.
- R4: Second-byte bit 4 set mirrors the glyph left to right, so pixel k takes glyph bit k instead of bit 7-k.
- R5: Second-byte bit 5 set mirrors the glyph top to bottom, so glyph row 7-r is read in place of row r.
- R6: In wide mode, the screen pair 0xFF,0xFF ends the line. Nothing more is drawn, `done` pulses, and `next_base` points just past the pair.
- R7: A row that starts with the end pair produces zero valid pixels and still pulses `done`.
- R8: With `wide_mode` low, each character uses one screen byte, is drawn 8 pixels wide and unmirrored, and a byte of 0xFF is an ordinary character.
- R9: One colour byte is read per character, at `col_base` plus the character's index within the row. A set glyph pixel outputs that byte and a clear pixel outputs `bg_colour`.
- R10: The line stops after MAX_PIX pixels, even in the middle of a character.
- R11: After reset the block is idle: no reads, no valid pixels, no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a line; accepted while idle |
| wide_mode | input | 1 | 1: two screen bytes per character; 0: one byte |
| row_base | input | ADDR_W | Address of the row's first screen byte |
| col_base | input | ADDR_W | Address of the row's first colour byte |
| raster_row | input | 3 | Pixel row within the character cell |
| bg_colour | input | 8 | Colour index for clear pixels |
| scr_rd | output | 1 | Screen memory read strobe |
| scr_addr | output | ADDR_W | Screen memory address |
| scr_data | input | 8 | Screen read data, one cycle after the strobe |
| chr_rd | output | 1 | Character memory read strobe |
| chr_addr | output | 15 | Character memory address |
| chr_data | input | 8 | Glyph byte, one cycle after the strobe |
| col_rd | output | 1 | Colour memory read strobe |
| col_addr | output | ADDR_W | Colour memory address |
| col_data | input | 8 | Colour byte, one cycle after the strobe |
| pix_valid | output | 1 | Pixel strobe |
| pix_colour | output | 8 | Pixel colour index |
| busy | output | 1 | Line in progress |
| done | output | 1 | One-cycle pulse when the line ends |
| next_base | output | ADDR_W | First screen byte not consumed |

## Verification
A wrong internal state shows up at the ports in a few ways. A mis-latched attribute byte shows up as a wrong pixel count or mirrored data within the first character that uses it. A stale end-of-row decision shows up as a non-zero pixel count on a row that holds only the end pair. A drifting screen pointer shows up as a wrong `next_base` at the `done` pulse. A drifting colour index shows up in the colour of the very next character drawn. The bench compares every pixel, in order, against a model built from the requirements, and checks the pixel count and `next_base` for each line. Most faults therefore appear within one character time.

// File: rtl/textrow_render.sv
module textrow_render #(
  parameter int ADDR_W  = 16,
  parameter int MAX_PIX = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide_mode,
  input  logic [ADDR_W-1:0] row_base,
  input  logic [ADDR_W-1:0] col_base,
  input  logic [2:0]        raster_row,
  input  logic [7:0]        bg_colour,
  output logic              scr_rd,
  output logic [ADDR_W-1:0] scr_addr,
  input  logic [7:0]        scr_data,
  output logic              chr_rd,
  output logic [14:0]       chr_addr,
  input  logic [7:0]        chr_data,
  output logic              col_rd,
  output logic [ADDR_W-1:0] col_addr,
  input  logic [7:0]        col_data,
  output logic              pix_valid,
  output logic [7:0]        pix_colour,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] next_base
);
  localparam int PCW = $clog2(MAX_PIX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_HI, S_GLY, S_GWAIT, S_PIX, S_DONE} state_t;
  state_t state;

  logic [ADDR_W-1:0] ptr, cidx, cbase;
  logic [PCW-1:0]    pcount;
  logic [2:0]        row, k;
  logic [7:0]        lo, hi, gly, colr;
  logic              wide_q;

  wire       at_limit = (pcount == PCW'(MAX_PIX));
  wire [2:0] klast    = 3'(7 - 2 * hi[7:6]);
  wire [2:0] eff_row  = hi[5] ? 3'(7 - row) : row;
  wire       pbit     = hi[4] ? gly[k] : gly[3'(7 - k)];
  wire       is_end   = (lo == 8'hFF) && (scr_data == 8'hFF);

  assign scr_rd     = (state == S_RD0 && !at_limit) || (state == S_RD1 && wide_q);
  assign scr_addr   = (state == S_RD1) ? ptr + ADDR_W'(1) : ptr;
  assign chr_rd     = (state == S_GLY);
  assign chr_addr   = {hi[3:0], lo, eff_row};
  assign col_rd     = (state == S_GLY);
  assign col_addr   = cbase + cidx;
  assign pix_valid  = (state == S_PIX);
  assign pix_colour = pbit ? colr : bg_colour;
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);
  assign next_base  = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ptr    <= '0;
      cidx   <= '0;
      cbase  <= '0;
      pcount <= '0;
      row    <= '0;
      k      <= '0;
      lo     <= '0;
      hi     <= '0;
      gly    <= '0;
      colr   <= '0;
      wide_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          ptr    <= row_base;
          cbase  <= col_base;
          cidx   <= '0;
          pcount <= '0;
          row    <= raster_row;
          wide_q <= wide_mode;
          state  <= S_RD0;
        end
        S_RD0: state <= at_limit ? S_DONE : S_RD1;
        S_RD1: begin
          lo <= scr_data;
          if (wide_q) state <= S_HI;
          else begin
            hi    <= 8'h00;
            ptr   <= ptr + ADDR_W'(1);
            state <= S_GLY;
          end
        end
        S_HI: begin
          ptr <= ptr + ADDR_W'(2);
          if (is_end) state <= S_DONE;
          else begin
            hi    <= scr_data;
            state <= S_GLY;
          end
        end
        S_GLY: state <= S_GWAIT;
        S_GWAIT: begin
          gly   <= chr_data;
          colr  <= col_data;
          k     <= '0;
          state <= S_PIX;
        end
        S_PIX: begin
          pcount <= pcount + PCW'(1);
          k      <= k + 3'd1;
          if (k == klast || pcount == PCW'(MAX_PIX - 1)) begin
            cidx  <= cidx + ADDR_W'(1);
            state <= S_RD0;
          end
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pix_valid && !scr_rd && !chr_rd && !done)); // R11
  AST_LINE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (pcount < PCW'(MAX_PIX))); // R10
  AST_COLOUR_WITH_GLYPH: assert property (@(posedge clk) disable iff (!rst_n)
    chr_rd |-> (col_rd && !scr_rd)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_MARKER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HI && is_end) |=> (done && !pix_valid)); // R6
  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (scr_rd && scr_addr == $past(row_base))); // R1
endmodule

// File: tb/textrow_render_bench.sv
module textrow_render_bench;
  localparam int ADDR_W = 16;
  localparam int MAX_PIX = 64;

  logic clk = 0, rst_n = 0, start = 0, wide_mode = 0;
  logic [ADDR_W-1:0] row_base = 0, col_base = 0;
  logic [2:0] raster_row = 0;
  logic [7:0] bg_colour = 8'h11;
  logic scr_rd, chr_rd, col_rd, pix_valid, busy, done;
  logic [ADDR_W-1:0] scr_addr, col_addr, next_base;
  logic [14:0] chr_addr;
  logic [7:0] scr_data, chr_data, col_data, pix_colour;

  logic [7:0] scr_mem [256];
  logic [7:0] col_mem [256];
  logic [7:0] act_q[$];
  logic [7:0] exp_q[$];
  logic [ADDR_W-1:0] exp_next;
  int checks = 0, fails = 0;
  int done_seen;

  always #5 clk = ~clk;

  textrow_render #(.ADDR_W(ADDR_W), .MAX_PIX(MAX_PIX)) u_textrow_render (
    .clk, .rst_n, .start, .wide_mode, .row_base, .col_base, .raster_row, .bg_colour,
    .scr_rd, .scr_addr, .scr_data, .chr_rd, .chr_addr, .chr_data,
    .col_rd, .col_addr, .col_data, .pix_valid, .pix_colour, .busy, .done, .next_base);

  function automatic logic [7:0] gbyte(input logic [14:0] a);
    return a[7:0] ^ 8'(a[14:8] * 8'd29) ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) begin
    if (scr_rd) scr_data <= scr_mem[scr_addr[7:0]];
    if (chr_rd) chr_data <= gbyte(chr_addr);
    if (col_rd) col_data <= col_mem[col_addr[7:0]];
  end

  always @(negedge clk) if (pix_valid) act_q.push_back(pix_colour);

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic build_expected(input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] cb,
                                input logic [2:0] r, input bit wide);
    logic [ADDR_W-1:0] p;
    logic [7:0] lo, hi, g, c;
    int cidx = 0;
    int w;
    p = base;
    exp_q.delete();
    while (exp_q.size() < MAX_PIX) begin
      lo = scr_mem[p[7:0]];
      if (wide) begin
        hi = scr_mem[8'(p[7:0] + 1)];
        p = p + 2;
        if (lo == 8'hFF && hi == 8'hFF) break;
      end else begin
        hi = 8'h00;
        p = p + 1;
      end
      g = gbyte({hi[3:0], lo, (hi[5] ? 3'(7 - r) : r)});
      c = col_mem[8'(cb + cidx)];
      w = 8 - 2 * hi[7:6];
      for (int kk = 0; kk < w && exp_q.size() < MAX_PIX; kk++)
        exp_q.push_back((hi[4] ? g[kk] : g[7 - kk]) ? c : bg_colour);
      cidx++;
    end
    exp_next = p;
  endtask

  task automatic run_row(input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] cb,
                         input logic [2:0] r, input bit wide, input string req);
    int t = 0;
    build_expected(base, cb, r, wide);
    act_q.delete();
    @(negedge clk);
    row_base = base; col_base = cb; raster_row = r; wide_mode = wide; start = 1;
    @(negedge clk);
    start = 0;
    done_seen = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    done_seen = done;
    @(negedge clk);
    check(done_seen == 1, req, "done pulse", done_seen, 1);
    check(act_q.size() == exp_q.size(), req, "pixel count", act_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < act_q.size(); i++)
      check(act_q[i] == exp_q[i], req, $sformatf("pixel %0d", i), act_q[i], exp_q[i]);
    check(next_base == exp_next, req, "next_base", next_base, exp_next);
  endtask

  task automatic put2(input int a, input logic [7:0] lo, input logic [7:0] hi);
    scr_mem[a] = lo; scr_mem[a + 1] = hi;
  endtask

  task automatic t_reset;
    check(!busy && !done && !pix_valid && !scr_rd && !chr_rd, "R11", "idle after reset",
          {busy, done, pix_valid, scr_rd, chr_rd}, 0);
  endtask

  task automatic t_full_width;
    // R1 R6 R9: 12-bit character numbers, full width, end pair mid-memory
    put2(0, 8'h35, 8'h0A); put2(2, 8'h00, 8'h0F); put2(4, 8'hC3, 8'h01);
    put2(6, 8'hFF, 8'hFF); put2(8, 8'h12, 8'h00);
    run_row(0, 16, 3'd2, 1'b1, "R1");
    check(act_q.size() == 24, "R6", "three chars then stop", act_q.size(), 24);
    check(next_base == 8, "R6", "next row base after marker", next_base, 8);
  endtask

  task automatic t_widths;
    // R2 R3: widths 8,6,4,2 packed
    put2(20, 8'h41, 8'h00); put2(22, 8'h42, 8'h40); put2(24, 8'h43, 8'h80);
    put2(26, 8'h44, 8'hC0); put2(28, 8'hFF, 8'hFF);
    run_row(20, 40, 3'd5, 1'b1, "R2");
    check(act_q.size() == 20, "R3", "packed width sum", act_q.size(), 20);
  endtask

  task automatic t_hflip;
    // R4
    put2(50, 8'h77, 8'h12); put2(52, 8'h77, 8'h02); put2(54, 8'hFF, 8'hFF);
    run_row(50, 60, 3'd1, 1'b1, "R4");
    if (act_q.size() == 16)
      for (int i = 0; i < 8; i++)
        check((act_q[i] == 8'h11) == (act_q[15 - i] == 8'h11), "R4", "mirror symmetry",
              act_q[i], act_q[15 - i]);
  endtask

  task automatic t_vflip;
    // R5
    put2(70, 8'h9C, 8'h23); put2(72, 8'hFF, 8'hFF);
    run_row(70, 80, 3'd6, 1'b1, "R5");
  endtask

  task automatic t_marker_only;
    // R7
    put2(90, 8'hFF, 8'hFF); put2(92, 8'h01, 8'h00);
    run_row(90, 0, 3'd0, 1'b1, "R7");
    check(act_q.size() == 0, "R7", "empty row pixel count", act_q.size(), 0);
  endtask

  task automatic t_byte_mode;
    // R8: 0xFF ordinary, hi attributes ignored
    scr_mem[100] = 8'hFF; scr_mem[101] = 8'hFF; scr_mem[102] = 8'hF3;
    for (int i = 103; i < 112; i++) scr_mem[i] = 8'(i * 7);
    run_row(100, 120, 3'd4, 1'b0, "R8");
    check(act_q.size() == MAX_PIX, "R8", "byte mode full line", act_q.size(), MAX_PIX);
    check(next_base == 108, "R8", "one byte per char", next_base, 108);
  endtask

  task automatic t_limit;
    // R10: 6 + 7*8 = 62, then 2 pixels of an 8-wide char
    put2(140, 8'h10, 8'h40);
    for (int i = 0; i < 9; i++) put2(142 + 2 * i, 8'(8'h20 + i), 8'h00);
    run_row(140, 200, 3'd3, 1'b1, "R10");
    check(act_q.size() == MAX_PIX, "R10", "cut at line limit", act_q.size(), MAX_PIX);
    check(next_base == 158, "R10", "cut char consumed", next_base, 158);
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        while (wd < 150000) begin @(posedge clk); wd++; end
        check(0, "ALL", "watchdog expired", wd, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none
    for (int i = 0; i < 256; i++) begin
      scr_mem[i] = 8'(i * 13 + 1);
      col_mem[i] = 8'(8'hA0 + i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_width();
    t_widths();
    t_hflip();
    t_vflip();
    t_marker_only();
    t_byte_mode();
    t_limit();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule